// File: doc/BRIEF.md
# Multi-Precision Floating-Point Flag Comparator

This block performs a quiet ordered comparison of two IEEE 754 values and encodes the outcome as a four-bit condition nibble: negative, zero, carry and overflow. One unit serves half, single and double precision, chosen per request by a two-bit format code. A select bit swaps the second operand for positive zero of the chosen width. Narrower formats occupy the low bits of the 64-bit operand buses, and the bits above them are ignored.

Each request is one cycle with `inValid` high. The result is registered and comes back one cycle later with `outValid`. An unsupported format code raises `undefFmt` and leaves the flag nibble as it was. The half-precision code is unsupported whenever `halfEnable` is low. An invalid-operation indication is raised only for signaling NaN inputs. A separate combinational port pulls the format, register-index and opcode fields out of a 32-bit instruction word for the surrounding decode logic.

Top module: `fpFlagCompare`

## Requirements
- R1: Format code 2'b00 selects 32-bit single, 2'b01 selects 64-bit double and 2'b11 selects 16-bit half precision. An operand occupies bits [W-1:0] of its bus, and bits at or above W do not affect the result.
- R2: Format code 2'b10 is undefined. The accepted request returns `outValid`=1 and `undefFmt`=1 with `invalidOp`=0, and `flagsNzcv` keeps its previous value.
- R3: While `halfEnable` is 0, format code 2'b11 is handled exactly like an undefined code, as in R2.
- R4: When `cmpZero` is 1, the second operand is positive zero of the selected width, and `opB` has no effect.
- R5: If either operand is a NaN (exponent all ones, fraction nonzero), `flagsNzcv` = 4'b0011.
- R6: `invalidOp` is 1 exactly when an operand is a signaling NaN, meaning the fraction MSB is 0. A quiet NaN (fraction MSB 1) gives unordered flags with `invalidOp` = 0.
- R7: `flagsNzcv` is packed {N,Z,C,V} from bit 3 down to bit 0. A equal to B gives 4'b0110, A less than B gives 4'b1000, and A greater than B gives 4'b0010.
- R8: Positive zero and negative zero compare as equal.
- R9: Subnormals compare by exact value with no flushing. Infinities order above or below every finite value, and equal infinities compare equal.
- R10: Results register on the edge that accepts `inValid`, and `outValid` is high for exactly that following cycle. Without a request, `outValid` is 0 and `flagsNzcv`, `invalidOp` and `undefFmt` hold.
- R11: The decode port returns instruction bits [23:22] as the format, [20:16] as the second register index, [9:5] as the first register index, and [4:3] as the opcode field. The opcode field's bit 0 is the compare-with-zero select.
- R12: While reset is asserted, `outValid`, `invalidOp` and `undefFmt` are 0 and `flagsNzcv` is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe |
| fmtCode | input | 2 | Precision select |
| cmpZero | input | 1 | Compare the first operand against +0 |
| halfEnable | input | 1 | Permits the half-precision code |
| opA | input | 64 | First operand, low-aligned |
| opB | input | 64 | Second operand, low-aligned |
| instrWord | input | 32 | Instruction word for field extraction |
| decFmt | output | 2 | Extracted format field |
| decRm | output | 5 | Extracted second register index |
| decRn | output | 5 | Extracted first register index |
| decOpc | output | 2 | Extracted opcode field |
| outValid | output | 1 | Result strobe, one cycle after the request |
| flagsNzcv | output | 4 | Condition flags {N,Z,C,V} |
| invalidOp | output | 1 | Signaling NaN seen |
| undefFmt | output | 1 | Request carried an unsupported format |

## Verification
The bench targets ordering cases where a plain sign-magnitude compare goes wrong.

- **Two negatives:** a design that skips reversing the order reports -2 above -1.
- **Mixed-sign zeros:** a design that checks the sign first reports -0 below +0.
- **Subnormals:** a design that flushes them calls the smallest value equal to zero.
- **NaNs:** each NaN class is applied to each operand. A design that raises invalid for quiet NaNs, or that tests the wrong fraction bit, shows up immediately.
- **Compare with zero:** `opB` carries junk chosen so that using it would change the answer.
- **Rejected formats:** these follow a known result, so a design that overwrites or clears the flags is caught.
- **Upper bus bits:** junk above the active width catches a wrong field slice.

// File: rtl/fpCmpPkg.sv
package fpCmpPkg;

  localparam int OPERAND_W = 64;
  localparam int FLAG_W    = 4;
  localparam int FMT_W     = 2;
  localparam int INSTR_W   = 32;
  localparam int REG_IDX_W = 5;
  localparam int OPC_W     = 2;

  // Exponent and fraction widths of the three formats.
  localparam int H_EXP  = 5;
  localparam int H_FRAC = 10;
  localparam int S_EXP  = 8;
  localparam int S_FRAC = 23;
  localparam int D_EXP  = 11;
  localparam int D_FRAC = 52;
  localparam int MAG_W  = D_EXP + D_FRAC;

  // Field positions inside the instruction word.
  localparam int FMT_LSB = 22;
  localparam int RM_LSB  = 16;
  localparam int RN_LSB  = 5;
  localparam int OPC_LSB = 3;

  typedef enum logic [FMT_W-1:0] {
    FMT_SINGLE = 2'b00,
    FMT_DOUBLE = 2'b01,
    FMT_RSVD   = 2'b10,
    FMT_HALF   = 2'b11
  } fmtCode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;
    logic loadFlags;
    logic markUndef;
  } ctrlStrobe_t;

  // Classification of one operand.
  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic             isZero;
    logic             isNan;
    logic             isSnan;
  } opClass_t;

  localparam logic [FLAG_W-1:0] NZCV_LT = 4'b1000;
  localparam logic [FLAG_W-1:0] NZCV_EQ = 4'b0110;
  localparam logic [FLAG_W-1:0] NZCV_GT = 4'b0010;
  localparam logic [FLAG_W-1:0] NZCV_UN = 4'b0011;

endpackage

// File: rtl/fpCmpClassify.sv
module fpCmpClassify
  import fpCmpPkg::*;
(
  input  logic [OPERAND_W-1:0] operand,
  input  logic                 forceZero,
  input  fmtCode_e             fmt,
  output opClass_t             cls
);
  localparam int NUM_FMT = 3;
  localparam int IDX_HALF   = 0;
  localparam int IDX_SINGLE = 1;
  localparam int IDX_DOUBLE = 2;
  localparam int EXP_W  [NUM_FMT] = '{H_EXP, S_EXP, D_EXP};
  localparam int FRAC_W [NUM_FMT] = '{H_FRAC, S_FRAC, D_FRAC};

  opClass_t cand [NUM_FMT];

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int EW = EXP_W[g];
    localparam int FW = FRAC_W[g];
    logic [EW-1:0] expField;
    logic [FW-1:0] fracField;
    logic          nanHit;

    assign expField  = operand[FW +: EW];
    assign fracField = operand[FW-1:0];
    assign nanHit    = (&expField) && (|fracField);
    // The bit pattern above the sign is monotonic in magnitude, so a
    // zero-extended copy orders correctly, including subnormals and infinity.
    assign cand[g] = {operand[EW+FW], MAG_W'({expField, fracField}),
                      (expField == '0) && (fracField == '0),
                      nanHit, nanHit && !fracField[FW-1]};
  end

  always_comb begin
    unique case (fmt)
      FMT_HALF:   cls = cand[IDX_HALF];
      FMT_DOUBLE: cls = cand[IDX_DOUBLE];
      default:    cls = cand[IDX_SINGLE];
    endcase
    if (forceZero) begin
      cls        = '0;
      cls.isZero = 1'b1;
    end
  end

endmodule

// File: rtl/fpCmpDatapath.sv
module fpCmpDatapath
  import fpCmpPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  fmtCode_e             fmt,
  input  logic                 cmpZero,
  input  logic [OPERAND_W-1:0] opA,
  input  logic [OPERAND_W-1:0] opB,
  output logic [FLAG_W-1:0]    flagsNzcv,
  output logic                 invalidOp,
  output logic                 undefFmt
);
  localparam int NUM_OPS = 2;

  logic [OPERAND_W-1:0] opBus  [NUM_OPS];
  logic                 zeroSel[NUM_OPS];
  opClass_t             cls    [NUM_OPS];

  assign opBus[0]   = opA;
  assign opBus[1]   = opB;
  assign zeroSel[0] = 1'b0;
  assign zeroSel[1] = cmpZero;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    fpCmpClassify u_classify (
      .operand  (opBus[i]),
      .forceZero(zeroSel[i]),
      .fmt      (fmt),
      .cls      (cls[i])
    );
  end

  logic [FLAG_W-1:0] nextFlags;
  logic              nextInvalid;

  always_comb begin
    nextInvalid = cls[0].isSnan || cls[1].isSnan;
    if (cls[0].isNan || cls[1].isNan)
      nextFlags = NZCV_UN;
    else if (cls[0].isZero && cls[1].isZero)
      nextFlags = NZCV_EQ;
    else if (cls[0].sign != cls[1].sign)
      nextFlags = cls[0].sign ? NZCV_LT : NZCV_GT;
    else if (cls[0].mag == cls[1].mag)
      nextFlags = NZCV_EQ;
    else if ((cls[0].mag < cls[1].mag) ^ cls[0].sign)
      nextFlags = NZCV_LT;
    else
      nextFlags = NZCV_GT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsNzcv <= '0;
      invalidOp <= 1'b0;
      undefFmt  <= 1'b0;
    end else if (strobe.capture) begin
      undefFmt <= strobe.markUndef;
      if (strobe.loadFlags) begin
        flagsNzcv <= nextFlags;
        invalidOp <= nextInvalid;
      end else begin
        invalidOp <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fpCmpControl.sv
module fpCmpControl
  import fpCmpPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [FMT_W-1:0]     fmtCode,
  input  logic                 halfEnable,
  input  logic [INSTR_W-1:0]   instrWord,
  output ctrlStrobe_t          strobe,
  output fmtCode_e             fmt,
  output logic                 outValid,
  output logic [FMT_W-1:0]     decFmt,
  output logic [REG_IDX_W-1:0] decRm,
  output logic [REG_IDX_W-1:0] decRn,
  output logic [OPC_W-1:0]     decOpc
);
  logic legalFmt;
  logic unusedInstrBits;

  assign fmt      = fmtCode_e'(fmtCode);
  assign legalFmt = (fmt != FMT_RSVD) && !((fmt == FMT_HALF) && !halfEnable);

  assign strobe.capture   = inValid;
  assign strobe.loadFlags = inValid && legalFmt;
  assign strobe.markUndef = inValid && !legalFmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  assign decFmt = instrWord[FMT_LSB +: FMT_W];
  assign decRm  = instrWord[RM_LSB  +: REG_IDX_W];
  assign decRn  = instrWord[RN_LSB  +: REG_IDX_W];
  assign decOpc = instrWord[OPC_LSB +: OPC_W];

  assign unusedInstrBits = ^{instrWord[INSTR_W-1:FMT_LSB+FMT_W],
                             instrWord[RM_LSB+REG_IDX_W +: 1],
                             instrWord[RM_LSB-1:RN_LSB+REG_IDX_W],
                             instrWord[OPC_LSB-1:0]};

endmodule

// File: rtl/fpFlagCompare.sv
module fpFlagCompare
  import fpCmpPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [FMT_W-1:0]     fmtCode,
  input  logic                 cmpZero,
  input  logic                 halfEnable,
  input  logic [OPERAND_W-1:0] opA,
  input  logic [OPERAND_W-1:0] opB,
  input  logic [INSTR_W-1:0]   instrWord,
  output logic [FMT_W-1:0]     decFmt,
  output logic [REG_IDX_W-1:0] decRm,
  output logic [REG_IDX_W-1:0] decRn,
  output logic [OPC_W-1:0]     decOpc,
  output logic                 outValid,
  output logic [FLAG_W-1:0]    flagsNzcv,
  output logic                 invalidOp,
  output logic                 undefFmt
);
  ctrlStrobe_t strobe;
  fmtCode_e    fmt;

  fpCmpControl u_control (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .fmtCode   (fmtCode),
    .halfEnable(halfEnable),
    .instrWord (instrWord),
    .strobe    (strobe),
    .fmt       (fmt),
    .outValid  (outValid),
    .decFmt    (decFmt),
    .decRm     (decRm),
    .decRn     (decRn),
    .decOpc    (decOpc)
  );

  fpCmpDatapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .fmt      (fmt),
    .cmpZero  (cmpZero),
    .opA      (opA),
    .opB      (opB),
    .flagsNzcv(flagsNzcv),
    .invalidOp(invalidOp),
    .undefFmt (undefFmt)
  );

endmodule

// File: rtl/fpCmpChecker.sv
module fpCmpChecker
  import fpCmpPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [FMT_W-1:0]  fmtCode,
  input logic              halfEnable,
  input logic              outValid,
  input logic [FLAG_W-1:0] flagsNzcv,
  input logic              invalidOp,
  input logic              undefFmt
);

  assert_out_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(flagsNzcv) && $stable(undefFmt) && $stable(invalidOp));

  assert_rsvd_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid && fmtCode == 2'b10 |=> undefFmt && $stable(flagsNzcv) && !invalidOp);

  assert_half_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    inValid && fmtCode == 2'b11 && !halfEnable |=> undefFmt && $stable(flagsNzcv));

  assert_snan_unordered_R6: assert property (@(posedge clk) disable iff (!rstN)
    invalidOp |-> flagsNzcv == NZCV_UN && !undefFmt);

  assert_legal_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !undefFmt |-> (flagsNzcv == NZCV_EQ || flagsNzcv == NZCV_LT ||
                               flagsNzcv == NZCV_GT || flagsNzcv == NZCV_UN));

endmodule

bind fpFlagCompare fpCmpChecker u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .fmtCode   (fmtCode),
  .halfEnable(halfEnable),
  .outValid  (outValid),
  .flagsNzcv (flagsNzcv),
  .invalidOp (invalidOp),
  .undefFmt  (undefFmt)
);

// File: tb/fpFlagCompare_bench.sv
module fpFlagCompare_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  fmtCode = 2'b00;
  logic        cmpZero = 1'b0;
  logic        halfEnable = 1'b1;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [31:0] instrWord = '0;
  logic [1:0]  decFmt;
  logic [4:0]  decRm;
  logic [4:0]  decRn;
  logic [1:0]  decOpc;
  logic        outValid;
  logic [3:0]  flagsNzcv;
  logic        invalidOp;
  logic        undefFmt;

  int checkCount = 0;
  int failCount  = 0;

  always #5 clk = ~clk;

  fpFlagCompare u_fpFlagCompare (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fmtCode(fmtCode),
    .cmpZero(cmpZero), .halfEnable(halfEnable), .opA(opA), .opB(opB),
    .instrWord(instrWord), .decFmt(decFmt), .decRm(decRm), .decRn(decRn),
    .decOpc(decOpc), .outValid(outValid), .flagsNzcv(flagsNzcv),
    .invalidOp(invalidOp), .undefFmt(undefFmt)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  fmt;
    logic        zero;
    logic [63:0] a;
    logic [63:0] b;
    logic [3:0]  nzcv;
    logic        inv;
  } vec_t;

  localparam int NUM_VEC = 22;
  localparam vec_t VECS [NUM_VEC] = '{
    '{4'd7, 2'b00, 1'b0, 64'h3F800000, 64'h40000000, 4'b1000, 1'b0},           // R7 1<2
    '{4'd7, 2'b00, 1'b0, 64'h40000000, 64'h3F800000, 4'b0010, 1'b0},           // R7 2>1
    '{4'd7, 2'b00, 1'b0, 64'h3F800000, 64'h3F800000, 4'b0110, 1'b0},           // R7 eq
    '{4'd7, 2'b01, 1'b0, 64'h3FF0000000000000, 64'hBFF0000000000000, 4'b0010, 1'b0}, // R7 1>-1
    '{4'd7, 2'b01, 1'b0, 64'hC000000000000000, 64'hBFF0000000000000, 4'b1000, 1'b0}, // R7 -2<-1
    '{4'd1, 2'b11, 1'b0, 64'hFFFFFFFFFFFF3C00, 64'h5A5A5A5A5A5A4000, 4'b1000, 1'b0}, // R1 half, junk above
    '{4'd8, 2'b00, 1'b0, 64'h00000000, 64'h80000000, 4'b0110, 1'b0},           // R8 +0==-0
    '{4'd8, 2'b01, 1'b0, 64'h8000000000000000, 64'h0, 4'b0110, 1'b0},          // R8 -0==+0
    '{4'd5, 2'b00, 1'b0, 64'h7FC00000, 64'h3F800000, 4'b0011, 1'b0},           // R5 qNaN
    '{4'd6, 2'b00, 1'b0, 64'h3F800000, 64'h7F800001, 4'b0011, 1'b1},           // R6 sNaN in B
    '{4'd6, 2'b11, 1'b0, 64'h7C01, 64'h7E00, 4'b0011, 1'b1},                   // R6 half sNaN vs qNaN
    '{4'd5, 2'b01, 1'b0, 64'h7FF8000000000000, 64'h7FF8000000000000, 4'b0011, 1'b0}, // R5 both qNaN
    '{4'd9, 2'b00, 1'b0, 64'h00000001, 64'h00000002, 4'b1000, 1'b0},           // R9 subnormals
    '{4'd9, 2'b00, 1'b0, 64'h00000001, 64'h80000000, 4'b0010, 1'b0},           // R9 subnormal > -0
    '{4'd9, 2'b00, 1'b0, 64'h7F800000, 64'h7F7FFFFF, 4'b0010, 1'b0},           // R9 +inf > max
    '{4'd9, 2'b00, 1'b0, 64'hFF800000, 64'hFF800000, 4'b0110, 1'b0},           // R9 -inf == -inf
    '{4'd9, 2'b01, 1'b0, 64'h7FEFFFFFFFFFFFFF, 64'h7FF0000000000000, 4'b1000, 1'b0}, // R9 max < inf
    '{4'd4, 2'b00, 1'b1, 64'hBF800000, 64'hBF800000, 4'b1000, 1'b0},           // R4 -1 vs 0, B would give eq
    '{4'd4, 2'b01, 1'b1, 64'h0, 64'h3FF0000000000000, 4'b0110, 1'b0},          // R4 0 vs 0, B would give lt
    '{4'd4, 2'b11, 1'b1, 64'h8001, 64'hFC00, 4'b1000, 1'b0},                   // R4 -sub vs 0, B would give gt
    '{4'd4, 2'b00, 1'b1, 64'h7FC00000, 64'h0, 4'b0011, 1'b0},                  // R4 qNaN vs 0
    '{4'd1, 2'b00, 1'b0, 64'hDEADBEEF3F800000, 64'h123456783F800000, 4'b0110, 1'b0} // R1 single, junk above
  };

  task automatic check(input string req, input logic [3:0] expFlags, input logic expInv,
                       input logic expUndef, input logic expValid);
    checkCount++;
    if (flagsNzcv !== expFlags || invalidOp !== expInv || undefFmt !== expUndef ||
        outValid !== expValid) begin
      failCount++;
      $display("FAIL %s: got flags=%b inv=%b undef=%b valid=%b, expected flags=%b inv=%b undef=%b valid=%b",
               req, flagsNzcv, invalidOp, undefFmt, outValid, expFlags, expInv, expUndef, expValid);
    end
  endtask

  task automatic drive(input logic [1:0] f, input logic z, input logic [63:0] a, input logic [63:0] b);
    fmtCode = f; cmpZero = z; opA = a; opB = b; inValid = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failCount++;
    checkCount++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    check("R12", 4'b0000, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R12", 4'b0000, 1'b0, 1'b0, 1'b0);

    // Vector table
    for (int i = 0; i < NUM_VEC; i++) begin
      drive(VECS[i].fmt, VECS[i].zero, VECS[i].a, VECS[i].b);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].nzcv, VECS[i].inv, 1'b0, 1'b1);
      inValid = 1'b0;
    end

    // R10: idle cycle holds results, outValid low; input changes ignored
    opA = 64'h7F800001; opB = 64'hFF800000;
    @(negedge clk);
    check("R10 idle", 4'b0110, 1'b0, 1'b0, 1'b0);

    // R2: reserved code with sNaN operands; flags held at 0110
    drive(2'b10, 1'b0, 64'h7F800001, 64'h3F800000);
    @(negedge clk);
    check("R2 reserved", 4'b0110, 1'b0, 1'b1, 1'b1);
    inValid = 1'b0;

    // sNaN result, then R2 must clear invalid and keep 0011
    drive(2'b00, 1'b0, 64'h7F800001, 64'h0);
    @(negedge clk);
    check("R6 snan", 4'b0011, 1'b1, 1'b0, 1'b1);
    drive(2'b10, 1'b0, 64'h0, 64'h3F800000);
    @(negedge clk);
    check("R2 clears invalid", 4'b0011, 1'b0, 1'b1, 1'b1);
    inValid = 1'b0;

    // R3: half disabled is undefined
    drive(2'b00, 1'b0, 64'h40000000, 64'h3F800000);
    @(negedge clk);
    check("R7 gt", 4'b0010, 1'b0, 1'b0, 1'b1);
    halfEnable = 1'b0;
    drive(2'b11, 1'b0, 64'h3C00, 64'h4000);
    @(negedge clk);
    check("R3 half gated", 4'b0010, 1'b0, 1'b1, 1'b1);
    halfEnable = 1'b1;
    drive(2'b11, 1'b0, 64'h3C00, 64'h4000);
    @(negedge clk);
    check("R3 half enabled", 4'b1000, 1'b0, 1'b0, 1'b1);

    // R10 back-to-back requests
    drive(2'b01, 1'b0, 64'h3FF0000000000000, 64'h3FF0000000000000);
    @(negedge clk);
    check("R10 b2b first", 4'b0110, 1'b0, 1'b0, 1'b1);
    inValid = 1'b0;
    @(negedge clk);
    check("R10 b2b gap", 4'b0110, 1'b0, 1'b0, 1'b0);

    // R11 decode port: fmt=11, Rm=0x15, Rn=0x0A, opc=01
    instrWord = 32'h1ED50148 | 32'h00D50148;
    #1;
    checkCount++;
    if (decFmt !== 2'b11 || decRm !== 5'h15 || decRn !== 5'h0A || decOpc !== 2'b01) begin
      failCount++;
      $display("FAIL R11: got %b %h %h %b, expected 11 15 0a 01", decFmt, decRm, decRn, decOpc);
    end
    instrWord = 32'h00000000 | (32'h2 << 22) | (32'h1F << 16) | (32'h03 << 5) | (32'h2 << 3);
    #1;
    checkCount++;
    if (decFmt !== 2'b10 || decRm !== 5'h1F || decRn !== 5'h03 || decOpc !== 2'b10) begin
      failCount++;
      $display("FAIL R11: got %b %h %h %b, expected 10 1f 03 10", decFmt, decRm, decRn, decOpc);
    end

    // R12 reset mid-run clears state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R12 rereset", 4'b0000, 1'b0, 1'b0, 1'b0);

    summary();
    $finish;
  end

endmodule